// File: doc/BRIEF.md
# Peripheral Interrupt Aggregation Controller

This block merges six interrupt sources of a host-bus slave peripheral into a single interrupt line for the local CPU. The six sources are:

- arrivals of host I/O cycles;
- arrivals of host TPM cycles;
- arrivals of host firmware cycles;
- a BT-style mailbox;
- two virtual UART queues.

Each source delivers a one-cycle event pulse. An enabled pulse sets a sticky flag. Software reads the flag back through a small register port and clears it by writing a one to it.

A control word holds one enable for each cycle-type source and one for the mailbox, plus a global enable. The global enable gates the merged output only: a flag still records its event while the global enable is 0. The virtual UART sources gate themselves upstream and always latch. Each of them also carries a two-bit cause (threshold reached or timeout), and the block keeps that cause next to the flag until software clears the flag.

The merged interrupt leaves the block through a register. It therefore follows a flag or enable change after one clock. Software reads the same registered value back in the status word.

Top module: `irq_agg_ctrl`

## Requirements
- R1: After reset, the control word (address 0) and the status word (address 1) both read 0, and `cpu_irq` is low. Any other address reads 0.
- R2: The control word keeps only these bits, and every other bit reads 0:
  - bit 0: global enable;
  - bit 16: mailbox enable;
  - bit 17: firmware-cycle enable;
  - bit 18: TPM-cycle enable;
  - bit 19: I/O-cycle enable.
- R3: An event on the I/O, TPM, firmware or mailbox source leaves the status word unchanged while that source's control enable is 0. This holds even when other sources are enabled.
- R4: Each source has a flag in the status word, and a flag stays set until software clears it. `src_evt` index 0..5 (UART1, UART2, mailbox, firmware, TPM, I/O) maps to status bit index+1.
- R5: Writing the status word clears each flag in bits 6:1 whose data bit is 1. Zero bits, bit 0 and bits 31:7 of the write have no effect.
- R6: An event that arrives in the same cycle as a clear of its own flag leaves the flag set.
- R7: `cpu_irq`, which status bit 0 mirrors, equals global enable AND (OR of flags 6:1). Both are taken one clock earlier.
- R8: With global enable 0, `cpu_irq` falls within one clock. The flags stay as they are.
- R9: Status bits 9:8 hold the UART1 cause and bits 11:10 hold the UART2 cause. The codes are 0 = none, 1 = threshold reached, 2 = timeout. A field is loaded from its cause input on every event of that UART and returns to 0 when its flag is cleared.
- R10: UART events set their flags whatever the value of control bits 19:16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 control, 1 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| src_evt | input | 6 | One-cycle source events, index 0..5 = UART1, UART2, mailbox, firmware, TPM, I/O |
| uart1_cause | input | 2 | Cause code sampled with UART1 event |
| uart2_cause | input | 2 | Cause code sampled with UART2 event |
| cpu_irq | output | 1 | Merged CPU interrupt (registered) |

## Verification
The bench targets the following corner cases:

- **Same-cycle event and clear.** A design that lets the clear win drops an interrupt without telling software.
- **Global enable toggled while flags stay set.** A design that gates the flags themselves loses pending state. A design that gates the output combinationally shows a zero-cycle instead of a one-cycle response.
- **Cause reloaded on a second event and zeroed on clear.** A design that loads the cause only on the first event reports a stale reason.
- **Disabled sources, status writes to bit 0 and reserved bits, and zero-data writes.** A design that decodes these carelessly sets or clears flags it should not touch.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int REG_W      = 32;
    localparam int NUM_SRC    = 6;
    localparam int NUM_CAUSED = 2;
    localparam int CAUSE_W    = 2;
    localparam int ADDR_W     = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;

    // Source indices; status bit = index + 1
    localparam int SRC_UART1 = 0;
    localparam int SRC_UART2 = 1;
    localparam int SRC_MBOX  = 2;
    localparam int SRC_FW    = 3;
    localparam int SRC_TPM   = 4;
    localparam int SRC_IO    = 5;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_THRESH  = 2'd1,
        CAUSE_TIMEOUT = 2'd2,
        CAUSE_RSVD    = 2'd3
    } cause_e;

    typedef struct packed {
        logic io_en;
        logic tpm_en;
        logic fw_en;
        logic mbox_en;
        logic glob_en;
    } ctrl_t;

    localparam logic [REG_W-1:0] CTRL_MASK = 32'h000F_0001;

    function automatic ctrl_t word_to_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.glob_en = w[0];
        c.mbox_en = w[16];
        c.fw_en   = w[17];
        c.tpm_en  = w[18];
        c.io_en   = w[19];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [REG_W-1:0] w;
        w     = '0;
        w[0]  = c.glob_en;
        w[16] = c.mbox_en;
        w[17] = c.fw_en;
        w[18] = c.tpm_en;
        w[19] = c.io_en;
        return w;
    endfunction

    function automatic logic [NUM_SRC-1:0] src_enables(input ctrl_t c);
        return {c.io_en, c.tpm_en, c.fw_en, c.mbox_en, 1'b1, 1'b1};
    endfunction

    function automatic logic [REG_W-1:0] status_word(
        input logic [NUM_SRC-1:0] flags,
        input logic               irq,
        input cause_e             c1,
        input cause_e             c2
    );
        logic [REG_W-1:0] w;
        w                 = '0;
        w[0]              = irq;
        w[NUM_SRC:1]      = flags;
        w[9:8]            = c1;
        w[11:10]          = c2;
        return w;
    endfunction

endpackage

// File: rtl/irq_agg_ctrl_reg.sv
module irq_agg_ctrl_reg
    import irq_agg_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output ctrl_t        ctrl_o
);
    logic [W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wdata & CTRL_MASK;
        end
    end

    assign ctrl_o = word_to_ctrl(ctrl_q);
endmodule

// File: rtl/irq_agg_flag.sv
module irq_agg_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clear_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clear_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/irq_agg_cause.sv
module irq_agg_cause
    import irq_agg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   set_i,
    input  logic   clear_i,
    input  cause_e cause_i,
    output cause_e cause_o
);
    cause_e cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= CAUSE_NONE;
        end else if (set_i) begin
            cause_q <= cause_i;
        end else if (clear_i) begin
            cause_q <= CAUSE_NONE;
        end
    end

    assign cause_o = cause_q;
endmodule

// File: rtl/irq_agg_combine.sv
module irq_agg_combine #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         glob_en,
    input  logic [N-1:0] flags,
    output logic         irq_o
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= glob_en & (|flags);
        end
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
    import irq_agg_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int AW     = ADDR_W,
    parameter int NSRC   = NUM_SRC,
    parameter int CW     = CAUSE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NSRC-1:0]   src_evt,
    input  logic [CW-1:0]     uart1_cause,
    input  logic [CW-1:0]     uart2_cause,
    output logic              cpu_irq
);
    localparam int CLR_LSB = 1;

    ctrl_t            ctrl_q;
    logic [NSRC-1:0]  src_en;
    logic [NSRC-1:0]  set_vec;
    logic [NSRC-1:0]  clr_vec;
    logic [NSRC-1:0]  flag_vec;
    cause_e           cause_in  [NUM_CAUSED];
    cause_e           cause_out [NUM_CAUSED];
    logic             ctrl_wr;
    logic             stat_wr;

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
    assign stat_wr = reg_wr && (reg_addr == ADDR_STAT);

    irq_agg_ctrl_reg #(.W(DATA_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (ctrl_wr),
        .wdata  (reg_wdata),
        .ctrl_o (ctrl_q)
    );

    assign src_en  = src_enables(ctrl_q);
    assign set_vec = src_evt & src_en;
    assign clr_vec = stat_wr ? reg_wdata[CLR_LSB +: NSRC] : '0;

    assign cause_in[0] = cause_e'(uart1_cause);
    assign cause_in[1] = cause_e'(uart2_cause);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        irq_agg_flag u_flag (
            .clk     (clk),
            .rst     (rst),
            .set_i   (set_vec[i]),
            .clear_i (clr_vec[i]),
            .flag_o  (flag_vec[i])
        );
        if (i < NUM_CAUSED) begin : g_cause
            irq_agg_cause u_cause (
                .clk     (clk),
                .rst     (rst),
                .set_i   (set_vec[i]),
                .clear_i (clr_vec[i]),
                .cause_i (cause_in[i]),
                .cause_o (cause_out[i])
            );
        end
    end

    irq_agg_combine #(.N(NSRC)) u_comb (
        .clk     (clk),
        .rst     (rst),
        .glob_en (ctrl_q.glob_en),
        .flags   (flag_vec),
        .irq_o   (cpu_irq)
    );

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = ctrl_to_word(ctrl_q);
            ADDR_STAT: reg_rdata = status_word(flag_vec, cpu_irq,
                                               cause_out[0], cause_out[1]);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_agg_ctrl_chk.sv
module irq_agg_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [5:0] wclr,
    input logic [5:0] src_evt,
    input logic [5:0] src_en,
    input logic       glob_en,
    input logic [5:0] flags,
    input logic [1:0] cause1,
    input logic [1:0] cause2,
    input logic       cpu_irq
);
    logic [5:0] clr_m;
    logic [5:0] set_m;
    assign clr_m = (reg_wr && reg_addr == 2'd1) ? wclr : 6'd0;
    assign set_m = src_evt & src_en;

    // R8: output falls one clock after global enable is 0
    p_mask_r8: assert property (@(posedge clk) disable iff (rst)
        !glob_en |=> !cpu_irq);

    // R7: no flags means no interrupt on the next cycle
    p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
        (flags == 6'd0) |=> !cpu_irq);

    // R4: a set flag not being cleared stays set
    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & $past(flags & ~clr_m)) == $past(flags & ~clr_m)));

    // R6: an enabled event always lands, clear or not
    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & $past(set_m)) == $past(set_m)));

    // R3: disabled sources cannot raise a flag
    p_disabled_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(src_en)) == 6'd0));

    // R9: a cause field is zero while its flag is clear
    p_cause1_r9: assert property (@(posedge clk) disable iff (rst)
        !flags[0] |-> (cause1 == 2'd0));
    p_cause2_r9: assert property (@(posedge clk) disable iff (rst)
        !flags[1] |-> (cause2 == 2'd0));
endmodule

bind irq_agg_ctrl irq_agg_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wclr     (reg_wdata[6:1]),
    .src_evt  (src_evt),
    .src_en   (src_en),
    .glob_en  (ctrl_q.glob_en),
    .flags    (flag_vec),
    .cause1   (cause_out[0]),
    .cause2   (cause_out[1]),
    .cpu_irq  (cpu_irq)
);

// File: tb/irq_agg_ctrl_tb.sv
module irq_agg_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  src_evt = '0;
    logic [1:0]  uart1_cause = '0;
    logic [1:0]  uart2_cause = '0;
    logic        cpu_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [31:0] data;
        logic        irq;
        string       req;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    irq_agg_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .src_evt     (src_evt),
        .uart1_cause (uart1_cause),
        .uart2_cause (uart2_cause),
        .cpu_irq     (cpu_irq)
    );

    // Monitor: pops one expected item per falling edge
    initial begin
        forever begin
            exp_t e;
            @(negedge clk);
            if (q.size() > 0) begin
                e = q.pop_front();
                n_tests++;
                if (reg_rdata !== e.data || cpu_irq !== e.irq) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                             e.req, reg_rdata, cpu_irq, e.data, e.irq);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [5:0] m, input logic [1:0] c1, input logic [1:0] c2);
        src_evt = m; uart1_cause = c1; uart2_cause = c2;
        tick();
        src_evt = '0;
    endtask

    task automatic wr_pulse(input logic [31:0] d, input logic [5:0] m,
                            input logic [1:0] c1, input logic [1:0] c2);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = d;
        src_evt = m; uart1_cause = c1; uart2_cause = c2;
        tick();
        reg_wr = 1'b0; reg_wdata = '0; src_evt = '0;
    endtask

    // Driver side of the scoreboard: push expectation, let the monitor compare
    task automatic chk(input logic [1:0] a, input logic [31:0] d,
                       input logic irq, input string req);
        exp_t e;
        reg_addr = a;
        e.data = d; e.irq = irq; e.req = req;
        q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        chk(2'd0, 32'h0, 1'b0, "R1 control after reset");
        chk(2'd1, 32'h0, 1'b0, "R1 status after reset");
        chk(2'd2, 32'h0, 1'b0, "R1 unmapped address");

        wr(2'd0, 32'hFFFF_FFFF);
        chk(2'd0, 32'h000F_0001, 1'b0, "R2 control keeps only its bits");
        wr(2'd0, 32'h0);
        pulse(6'h3C, 2'd0, 2'd0);
        chk(2'd1, 32'h0, 1'b0, "R3 disabled sources ignored");

        wr(2'd0, 32'h000F_0000);
        pulse(6'h20, 2'd0, 2'd0);
        chk(2'd1, 32'h40, 1'b0, "R4 I/O flag at status bit 6");
        tick();
        chk(2'd1, 32'h40, 1'b0, "R8 global enable off keeps irq low");

        wr(2'd0, 32'h000F_0001);
        chk(2'd1, 32'h40, 1'b0, "R7 irq not yet up in enable cycle");
        tick();
        chk(2'd1, 32'h41, 1'b1, "R7 irq one clock after enable");

        wr(2'd1, 32'h40);
        chk(2'd1, 32'h01, 1'b1, "R5 flag cleared, irq lags one clock");
        tick();
        chk(2'd1, 32'h00, 1'b0, "R7 irq drops after clear");

        wr(2'd0, 32'h0000_0001);
        pulse(6'h01, 2'd1, 2'd0);
        chk(2'd1, 32'h102, 1'b0, "R10 UART1 latches with bits 19:16 clear");
        tick();
        chk(2'd1, 32'h103, 1'b1, "R9 UART1 cause threshold");
        pulse(6'h01, 2'd2, 2'd0);
        chk(2'd1, 32'h203, 1'b1, "R9 UART1 cause reloaded to timeout");
        pulse(6'h02, 2'd0, 2'd2);
        chk(2'd1, 32'hA07, 1'b1, "R9 UART2 cause timeout");
        wr(2'd1, 32'h2);
        chk(2'd1, 32'h805, 1'b1, "R9 cause returns to 0 on clear");

        wr_pulse(32'h4, 6'h02, 2'd0, 2'd1);
        chk(2'd1, 32'h405, 1'b1, "R6 event beats same-cycle clear");

        wr(2'd1, 32'hFFFF_F081);
        chk(2'd1, 32'h405, 1'b1, "R5 bit 0 and reserved writes ignored");
        wr(2'd1, 32'h0);
        chk(2'd1, 32'h405, 1'b1, "R5 zero write ignored");

        wr(2'd0, 32'h0);
        chk(2'd1, 32'h405, 1'b1, "R8 irq holds in disable cycle");
        tick();
        chk(2'd1, 32'h404, 1'b0, "R8 irq low, flags retained");

        wr(2'd0, 32'h000F_0001);
        pulse(6'h3F, 2'd2, 2'd2);
        chk(2'd1, 32'hA7F, 1'b1, "R4 all six flags set");
        wr(2'd1, 32'h7E);
        chk(2'd1, 32'h001, 1'b1, "R5 clear all flags");
        tick();
        chk(2'd1, 32'h000, 1'b0, "R7 irq low after clear all");

        wr(2'd0, 32'h0001_0001);
        pulse(6'h24, 2'd0, 2'd0);
        chk(2'd1, 32'h08, 1'b0, "R3 I/O disabled while mailbox enabled");
        tick();
        chk(2'd1, 32'h09, 1'b1, "R7 mailbox raises irq");
        chk(2'd0, 32'h0001_0001, 1'b1, "R2 control readback");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule